// File: doc/BRIEF.md
# Descriptor Ring Receive DMA Engine

This block takes an incoming stream of report bytes and lands them in host memory. Host memory is described by a circular buffer of scatter-gather tables. Every table has the same programmed number of 128-bit entries. Each entry names a destination address, a byte count, a table-end marker and a completion-interrupt request. One frame from the stream fills one whole table. The engine fetches entries in order over a descriptor read port and writes one payload byte per cycle over a memory write port. When an entry is done, it reports a two-bit completion status for that entry on a status write port.

Software programs the ring depth, the entries per table and the base address of the table area. Software also owns the write pointer. The engine owns the read pointer. Both pointers carry a rollover flag in bit 7, above a 7-bit index. When a frame ends, the read pointer moves on by one table. A sticky end-of-frame flag is set, and an interrupt pulse is raised if software enabled it. When every table holds a frame that software has not yet freed, the engine stops accepting input.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, rd_ptr is 0x00, ring_empty is 1, ring_full is 0, eof_sts and irq are 0, and in_ready, desc_req, wr_en and wb_en are all 0.
- R2: The read pointer steps once per finished frame. The index in bits 6:0 counts up to cfg_depth_m1, then returns to 0 and bit 7 toggles, so depth 4 gives 00,01,02,03,80,81,82,83,00. The pointer is stable between frame ends.
- R3: ring_full is 1 when the pointer indices match and bit 7 differs. While ring_full is 1, in_ready, desc_req and wr_en stay 0.
- R4: ring_empty is 1 exactly when rd_ptr equals sw_wr_ptr.
- R5: Entry k of table n is fetched from cfg_base + (n*(cfg_entries_m1+1) + k)*16, where n is the index part of rd_ptr.
- R6: Entry fields are: destination in bits 53:0, completion-interrupt request in bit 63, byte count in bits 87:64, and table end in bit 88. The bytes that go into an entry are written one per cycle to the destination, the destination+1, and so on.
- R7: Entries are used in increasing order. An entry is the table's last when bit 88 is set or its number equals cfg_entries_m1. When a full entry is not the last, the next entry is fetched. An entry with a byte count of 0 completes without taking a byte.
- R8: A frame ends when a byte with in_last is accepted. That entry reports status 00 on the status port at its own entry address, and every entry filled before it reports 00.
- R9: If the last entry of a table fills before in_last, it reports status 01. The remaining bytes of the frame are accepted and discarded up to in_last, and no memory write happens for them.
- R10: At every frame end eof_sts is set, and it stays set until eof_clr. An irq pulse is raised for the frame end only when cfg_eof_irq_en is 1.
- R11: An entry with bit 63 set raises a one-cycle irq pulse when it completes. If this coincides with an enabled frame-end pulse, the two give a single pulse.
- R12: While cfg_enable is 0, no new frame is started: in_ready and desc_req stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Allows new frames to start |
| cfg_depth_m1 | input | 7 | Number of tables in the ring minus one |
| cfg_entries_m1 | input | 8 | Entries per table minus one |
| cfg_base | input | 54 | Byte address of table 0, entry 0 |
| cfg_eof_irq_en | input | 1 | Enables the frame-end interrupt pulse |
| sw_wr_ptr | input | 8 | Software write pointer, bit 7 = rollover |
| eof_clr | input | 1 | Clears eof_sts |
| rd_ptr | output | 8 | Hardware read pointer, bit 7 = rollover |
| ring_empty | output | 1 | Pointers equal |
| ring_full | output | 1 | Indices equal, rollover differs |
| eof_sts | output | 1 | Sticky end-of-frame flag |
| irq | output | 1 | One-cycle interrupt pulse |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Stream byte accepted when high with in_valid |
| desc_req | output | 1 | Descriptor read request, held until desc_valid |
| desc_addr | output | 54 | Descriptor entry address |
| desc_valid | input | 1 | Descriptor data returned |
| desc_data | input | 128 | Descriptor entry contents |
| wr_en | output | 1 | Payload byte write strobe |
| wr_addr | output | 54 | Payload byte address |
| wr_data | output | 8 | Payload byte |
| wb_en | output | 1 | Entry completion status strobe |
| wb_addr | output | 54 | Address of the completed entry |
| wb_status | output | 2 | Status for bits 90:89: 00 normal, 01 truncated |

## Verification
Memory writes, descriptor requests and status writes are combinational from the engine state and the stream input, so they appear in the same cycle as the byte or descriptor that causes them. The bench compares them against queued reference events at a sample point 2 ns before each rising edge. The read pointer, eof_sts and irq are registered at the edge that accepts the final byte of a frame, or the byte that ends a table. They are checked in the following cycle, and the bench counts irq pulses over a two-cycle window after each frame. A stall or an ignored input is checked at every sample point while it is applied, and the bench reads in_ready and desc_req there.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int ADDR_W  = 54;
    localparam int LEN_W   = 24;
    localparam int DESC_W  = 128;
    localparam int ENT_BYTES_LOG2 = 4;

    localparam int IOC_BIT = 63;
    localparam int LEN_LSB = 64;
    localparam int EOT_BIT = 88;

    localparam logic [1:0] WB_OK    = 2'b00;
    localparam logic [1:0] WB_TRUNC = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MOVE  = 2'd2,
        ST_DROP  = 2'd3
    } eng_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic              ioc;
        logic [LEN_W-1:0]  len;
        logic              eot;
    } entry_t;

    function automatic entry_t entry_decode(input logic [DESC_W-1:0] raw);
        entry_t e;
        e.dst = raw[ADDR_W-1:0];
        e.ioc = raw[IOC_BIT];
        e.len = raw[LEN_LSB +: LEN_W];
        e.eot = raw[EOT_BIT];
        return e;
    endfunction

endpackage

// File: rtl/rxdma_ptr.sv
module rxdma_ptr #(
    parameter int IDX_W = 7,
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [IDX_W-1:0] depth_m1,
    input  logic [PTR_W-1:0] sw_ptr,
    output logic [PTR_W-1:0] hw_ptr,
    output logic             full,
    output logic             empty
);

    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            if (ptr_q[IDX_W-1:0] == depth_m1) begin
                ptr_d = {~ptr_q[IDX_W], {IDX_W{1'b0}}};
            end else begin
                ptr_d = {ptr_q[IDX_W], ptr_q[IDX_W-1:0] + IDX_W'(1)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign hw_ptr = ptr_q;
    assign empty  = (ptr_q == sw_ptr);
    assign full   = (ptr_q[IDX_W-1:0] == sw_ptr[IDX_W-1:0]) && (ptr_q[IDX_W] != sw_ptr[IDX_W]);

endmodule

// File: rtl/rxdma_addr.sv
module rxdma_addr
    import rxdma_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int ENT_W = 8,
    localparam int PROD_W = IDX_W + ENT_W + 1,
    localparam int OFF_W  = PROD_W + 1 + ENT_BYTES_LOG2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [ENT_W-1:0]  entries_m1,
    input  logic [ENT_W-1:0]  ent_idx,
    output logic [ADDR_W-1:0] ent_addr
);

    logic [PROD_W-1:0] slot;
    logic [OFF_W-1:0]  byte_off;

    always_comb begin
        slot     = PROD_W'(tbl_idx) * PROD_W'({1'b0, entries_m1} + (ENT_W+1)'(1));
        byte_off = OFF_W'({1'b0, slot} + (PROD_W+1)'(ent_idx)) << ENT_BYTES_LOG2;
        ent_addr = base + {{(ADDR_W-OFF_W){1'b0}}, byte_off};
    end

endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
    import rxdma_pkg::*;
#(
    parameter int ENT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ring_full,
    input  logic [ENT_W-1:0]  entries_m1,
    input  logic              eof_irq_en,
    input  logic              eof_clr,
    input  logic [ADDR_W-1:0] ent_addr,
    output logic [ENT_W-1:0]  ent_idx,
    output logic              frame_adv,
    output logic              eof_sts,
    output logic              irq,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              desc_req,
    input  logic              desc_valid,
    input  logic [DESC_W-1:0] desc_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wb_en,
    output logic [1:0]        wb_status
);

    typedef struct packed {
        eng_st_e          st;
        logic [ENT_W-1:0] k;
        logic [LEN_W-1:0] off;
        entry_t           cur;
        logic             eof_sts;
        logic             irq;
    } ctrl_t;

    ctrl_t  ctl_d, ctl_q;
    entry_t fetched;
    logic   fetched_last, cur_last, entry_full, frame_end, entry_irq;
    logic   unused_desc_bits;

    assign unused_desc_bits = ^{desc_data[DESC_W-1:EOT_BIT+1], desc_data[IOC_BIT-1:ADDR_W]};

    always_comb begin
        ctl_d        = ctl_q;
        fetched      = entry_decode(desc_data);
        fetched_last = fetched.eot || (ctl_q.k == entries_m1);
        cur_last     = ctl_q.cur.eot || (ctl_q.k == entries_m1);
        entry_full   = ((ctl_q.off + LEN_W'(1)) == ctl_q.cur.len);
        desc_req     = 1'b0;
        in_ready     = 1'b0;
        wr_en        = 1'b0;
        wr_addr      = ctl_q.cur.dst + {{(ADDR_W-LEN_W){1'b0}}, ctl_q.off};
        wr_data      = in_data;
        wb_en        = 1'b0;
        wb_status    = WB_OK;
        frame_end    = 1'b0;
        entry_irq    = 1'b0;

        if (eof_clr) ctl_d.eof_sts = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.k = '0;
                if (enable && !ring_full && in_valid) ctl_d.st = ST_FETCH;
            end
            ST_FETCH: begin
                desc_req = 1'b1;
                if (desc_valid) begin
                    ctl_d.cur = fetched;
                    ctl_d.off = '0;
                    if (fetched.len == '0) begin
                        wb_en     = 1'b1;
                        entry_irq = fetched.ioc;
                        if (fetched_last) begin
                            wb_status = WB_TRUNC;
                            ctl_d.st  = ST_DROP;
                        end else begin
                            ctl_d.k = ctl_q.k + ENT_W'(1);
                        end
                    end else begin
                        ctl_d.st = ST_MOVE;
                    end
                end
            end
            ST_MOVE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    wr_en     = 1'b1;
                    ctl_d.off = ctl_q.off + LEN_W'(1);
                    if (in_last) begin
                        wb_en     = 1'b1;
                        entry_irq = ctl_q.cur.ioc;
                        frame_end = 1'b1;
                        ctl_d.st  = ST_IDLE;
                    end else if (entry_full) begin
                        wb_en     = 1'b1;
                        entry_irq = ctl_q.cur.ioc;
                        if (cur_last) begin
                            wb_status = WB_TRUNC;
                            ctl_d.st  = ST_DROP;
                        end else begin
                            ctl_d.k  = ctl_q.k + ENT_W'(1);
                            ctl_d.st = ST_FETCH;
                        end
                    end
                end
            end
            ST_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) begin
                    frame_end = 1'b1;
                    ctl_d.st  = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (frame_end) ctl_d.eof_sts = 1'b1;
        ctl_d.irq = entry_irq || (frame_end && eof_irq_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ent_idx   = ctl_q.k;
    assign frame_adv = frame_end;
    assign eof_sts   = ctl_q.eof_sts;
    assign irq       = ctl_q.irq;

endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
    import rxdma_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int ENT_W = 8,
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [IDX_W-1:0]  cfg_depth_m1,
    input  logic [ENT_W-1:0]  cfg_entries_m1,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_eof_irq_en,
    input  logic [PTR_W-1:0]  sw_wr_ptr,
    input  logic              eof_clr,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              ring_empty,
    output logic              ring_full,
    output logic              eof_sts,
    output logic              irq,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              desc_req,
    output logic [ADDR_W-1:0] desc_addr,
    input  logic              desc_valid,
    input  logic [DESC_W-1:0] desc_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [1:0]        wb_status
);

    logic              frame_adv;
    logic [ENT_W-1:0]  ent_idx;
    logic [ADDR_W-1:0] ent_addr;

    rxdma_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (frame_adv),
        .depth_m1 (cfg_depth_m1),
        .sw_ptr   (sw_wr_ptr),
        .hw_ptr   (rd_ptr),
        .full     (ring_full),
        .empty    (ring_empty)
    );

    rxdma_addr #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_addr (
        .base       (cfg_base),
        .tbl_idx    (rd_ptr[IDX_W-1:0]),
        .entries_m1 (cfg_entries_m1),
        .ent_idx    (ent_idx),
        .ent_addr   (ent_addr)
    );

    rxdma_ctrl #(.ENT_W(ENT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .ring_full  (ring_full),
        .entries_m1 (cfg_entries_m1),
        .eof_irq_en (cfg_eof_irq_en),
        .eof_clr    (eof_clr),
        .ent_addr   (ent_addr),
        .ent_idx    (ent_idx),
        .frame_adv  (frame_adv),
        .eof_sts    (eof_sts),
        .irq        (irq),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .desc_req   (desc_req),
        .desc_valid (desc_valid),
        .desc_data  (desc_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wb_en      (wb_en),
        .wb_status  (wb_status)
    );

    assign desc_addr = ent_addr;
    assign wb_addr   = ent_addr;

endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_adv,
    input logic [PTR_W-1:0] rd_ptr,
    input logic             ring_full,
    input logic             in_ready,
    input logic             desc_req,
    input logic             wr_en,
    input logic             eof_sts,
    input logic             eof_clr
);

    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_adv |=> $stable(rd_ptr))
        else $error("pointer moved without frame end");

    p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full |-> (!in_ready && !desc_req && !wr_en))
        else $error("engine active while ring full");

    p_req_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_req, in_ready}))
        else $error("fetch and stream accept together");

    p_eof_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eof_sts) |-> (rd_ptr != $past(rd_ptr)))
        else $error("end-of-frame flag without pointer step");

    p_eof_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_clr && !frame_adv) |=> !eof_sts)
        else $error("end-of-frame flag survived clear");

endmodule

bind rx_ring_dma rx_ring_dma_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_adv (frame_adv),
    .rd_ptr    (rd_ptr),
    .ring_full (ring_full),
    .in_ready  (in_ready),
    .desc_req  (desc_req),
    .wr_en     (wr_en),
    .eof_sts   (eof_sts),
    .eof_clr   (eof_clr)
);

// File: tb/test_rx_ring_dma.sv
module test_rx_ring_dma;

    localparam longint BASE = 64'h1000;
    localparam int     ENT  = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_enable = 1'b0;
    logic [6:0]   cfg_depth_m1 = 7'd3;
    logic [7:0]   cfg_entries_m1 = 8'(ENT - 1);
    logic [53:0]  cfg_base = 54'(BASE);
    logic         cfg_eof_irq_en = 1'b1;
    logic [7:0]   sw_wr_ptr = 8'h00;
    logic         eof_clr = 1'b0;
    logic [7:0]   rd_ptr;
    logic         ring_empty, ring_full, eof_sts, irq;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = 8'h00;
    logic         in_last = 1'b0;
    logic         in_ready;
    logic         desc_req;
    logic [53:0]  desc_addr;
    logic         desc_valid = 1'b0;
    logic [127:0] desc_data = '0;
    logic         wr_en;
    logic [53:0]  wr_addr;
    logic [7:0]   wr_data;
    logic         wb_en;
    logic [53:0]  wb_addr;
    logic [1:0]   wb_status;

    always #10 clk = ~clk;

    rx_ring_dma i_rx_ring_dma (.*);

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int irq_seen = 0;
    bit done     = 0;

    logic [127:0] dmem [longint];
    longint       fetch_q [$];
    longint       wa_q    [$];
    int           wd_q    [$];
    longint       wba_q   [$];
    int           wbs_q   [$];
    int           m_idx   = 0;
    int           m_roll  = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint ent_addr(input int n, input int k);
        return BASE + longint'((n * ENT + k) * 16);
    endfunction

    task automatic set_desc(input int n, input int k, input longint dst, input int len,
                            input bit eot, input bit ioc);
        logic [127:0] d;
        d = '0;
        d[53:0]  = 54'(dst);
        d[63]    = ioc;
        d[87:64] = 24'(len);
        d[88]    = eot;
        dmem[ent_addr(n, k)] = d;
    endtask

    function automatic int byte_val(input int fid, input int i);
        return (fid * 37 + i * 5 + 1) % 256;
    endfunction

    // Reference model: queues the fetches, writes and status reports a frame must produce
    task automatic plan_frame(input int nbytes, input int fid, input bit eofen, output int irq_exp);
        int rem, pos, k, cnt;
        bit merged;
        logic [127:0] d;
        longint a, dst;
        int len;
        bit last, ioc;
        rem = nbytes; pos = 0; k = 0; cnt = 0; merged = 0;
        forever begin
            a = ent_addr(m_idx, k);
            fetch_q.push_back(a);
            d = dmem.exists(a) ? dmem[a] : '0;
            dst = longint'(d[53:0]); len = int'(d[87:64]);
            last = d[88] || (k == ENT - 1); ioc = d[63];
            if (len == 0) begin
                wba_q.push_back(a); cnt += ioc;
                if (last) begin wbs_q.push_back(1); break; end
                wbs_q.push_back(0); k++; continue;
            end
            for (int j = 0; j < len && rem > 0; j++) begin
                wa_q.push_back(dst + j); wd_q.push_back(byte_val(fid, pos));
                pos++; rem--;
            end
            wba_q.push_back(a); cnt += ioc;
            if (rem == 0) begin wbs_q.push_back(0); merged = ioc && eofen; break; end
            if (last) begin wbs_q.push_back(1); break; end
            wbs_q.push_back(0); k++;
        end
        irq_exp = cnt + int'(eofen) - int'(merged);
        if (m_idx == int'(cfg_depth_m1)) begin m_idx = 0; m_roll ^= 1; end
        else m_idx++;
    endtask

    function automatic int model_ptr();
        return m_roll * 128 + m_idx;
    endfunction

    // Descriptor memory responder
    initial forever begin
        @(negedge clk);
        desc_valid = desc_req;
        desc_data  = (desc_req && dmem.exists(longint'(desc_addr))) ? dmem[longint'(desc_addr)] : '0;
    end

    // Per-cycle comparison against the reference queues, 2 ns before each rising edge
    initial forever begin
        @(negedge clk);
        #8;
        cycles++;
        if (cycles > 100000 && !done) begin
            chk(0, "watchdog", cycles, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
        if (rst_n) begin
            if (desc_req && desc_valid) begin
                if (fetch_q.size() == 0) chk(0, "R5 unexpected fetch", longint'(desc_addr), 0);
                else begin
                    longint e; e = fetch_q.pop_front();
                    chk(longint'(desc_addr) == e, "R5 fetch address", longint'(desc_addr), e);
                end
            end
            if (wr_en) begin
                if (wa_q.size() == 0) chk(0, "R9 write after table end", longint'(wr_addr), 0);
                else begin
                    longint ea; int ed;
                    ea = wa_q.pop_front(); ed = wd_q.pop_front();
                    chk(longint'(wr_addr) == ea, "R6 byte address", longint'(wr_addr), ea);
                    chk(int'(wr_data) == ed, "R6 byte value", longint'(wr_data), longint'(ed));
                end
            end
            if (wb_en) begin
                if (wba_q.size() == 0) chk(0, "R8 unexpected status", longint'(wb_addr), 0);
                else begin
                    longint ea; int es;
                    ea = wba_q.pop_front(); es = wbs_q.pop_front();
                    chk(longint'(wb_addr) == ea, "R8 status address", longint'(wb_addr), ea);
                    chk(int'(wb_status) == es, es ? "R9 truncation status" : "R8 normal status",
                        longint'(wb_status), longint'(es));
                end
            end
            if (irq) irq_seen++;
            if (ring_full && in_valid)
                chk(!in_ready && !desc_req, "R3 stall while full", {in_ready, desc_req}, 0);
            if (!cfg_enable && in_valid)
                chk(!in_ready && !desc_req, "R12 disabled", {in_ready, desc_req}, 0);
            chk(ring_empty == (rd_ptr == sw_wr_ptr), "R4 empty flag", ring_empty, rd_ptr == sw_wr_ptr);
        end
    end

    task automatic send_frame(input int nb, input int fid);
        bit acc;
        for (int i = 0; i < nb; i++) begin
            in_valid = 1'b1;
            in_data  = 8'(byte_val(fid, i));
            in_last  = (i == nb - 1);
            do begin
                #8; acc = in_ready;
                @(negedge clk);
            end while (!acc);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_frame(input int nb, input int fid, input bit eofen, input string tag);
        int exp_irq, base_irq;
        cfg_eof_irq_en = eofen;
        base_irq = irq_seen;
        plan_frame(nb, fid, eofen, exp_irq);
        send_frame(nb, fid);
        chk(int'(rd_ptr) == model_ptr(), {tag, " R2 read pointer"}, rd_ptr, model_ptr());
        chk(eof_sts == 1'b1, {tag, " R10 eof flag"}, eof_sts, 1);
        @(negedge clk); @(negedge clk);
        chk(irq_seen - base_irq == exp_irq, {tag, " R10/R11 irq pulses"}, irq_seen - base_irq, exp_irq);
        chk(fetch_q.size() + wa_q.size() + wba_q.size() == 0, {tag, " R7 all events seen"},
            fetch_q.size() + wa_q.size() + wba_q.size(), 0);
    endtask

    initial begin
        // Tables 0..3, three entries each
        set_desc(0, 0, 64'h10000, 8, 0, 0);
        set_desc(0, 1, 64'h10100, 8, 0, 0);
        set_desc(0, 2, 64'h10200, 8, 1, 0);
        set_desc(1, 0, 64'h20000, 8, 0, 0);
        set_desc(1, 1, 64'h20400, 8, 0, 1);
        set_desc(1, 2, 64'h20800, 8, 1, 0);
        set_desc(2, 0, 64'h30000, 8, 0, 0);
        set_desc(2, 1, 64'h31000, 8, 0, 0);
        set_desc(2, 2, 64'h32000, 8, 1, 0);
        set_desc(3, 0, 64'h40000, 8, 0, 1);
        set_desc(3, 1, 64'h40100, 8, 0, 0);
        set_desc(3, 2, 64'h40200, 8, 0, 0);

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rd_ptr == 8'h00, "R1 rd_ptr", rd_ptr, 0);
        chk(ring_empty && !ring_full, "R1 ring flags", {ring_empty, ring_full}, 2);
        chk(!eof_sts && !irq, "R1 eof/irq", {eof_sts, irq}, 0);
        chk(!in_ready && !desc_req && !wr_en && !wb_en, "R1 idle outputs",
            {in_ready, desc_req, wr_en, wb_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: disabled engine ignores a waiting byte
        in_valid = 1'b1; in_data = 8'h55; in_last = 1'b0;
        repeat (10) @(negedge clk);
        chk(rd_ptr == 8'h00 && !eof_sts, "R12 no frame while disabled", rd_ptr, 0);
        in_valid = 1'b0;
        cfg_enable = 1'b1;
        @(negedge clk);

        // R8: short frame ends inside entry 0
        run_frame(5, 1, 1, "A");
        eof_clr = 1'b1; @(negedge clk); eof_clr = 1'b0; @(negedge clk);
        chk(!eof_sts, "R10 eof clear", eof_sts, 0);
        // R7/R11: spans three entries, middle entry requests irq
        run_frame(20, 2, 1, "B");
        // R9: truncated frame, frame-end irq disabled
        run_frame(30, 3, 0, "C");
        // R11: exact fill of entry 0 with its irq merged into the frame-end pulse
        run_frame(8, 4, 1, "D");
        chk(rd_ptr == 8'h80, "R2 rollover to 80", rd_ptr, 8'h80);

        // R3: ring full, input held for a while
        chk(ring_full && !ring_empty, "R3 full flag", {ring_full, ring_empty}, 2);
        in_valid = 1'b1; in_data = 8'hAA; in_last = 1'b0;
        repeat (12) @(negedge clk);
        chk(rd_ptr == 8'h80 && wa_q.size() == 0, "R3 no progress while full", rd_ptr, 8'h80);
        in_valid = 1'b0;
        sw_wr_ptr = 8'h80;
        @(negedge clk);
        chk(ring_empty && !ring_full, "R4 empty after software frees all", {ring_empty, ring_full}, 2);

        eof_clr = 1'b1; @(negedge clk); eof_clr = 1'b0;
        run_frame(3, 5, 1, "E");
        // R7: zero-length first entry in table 1
        set_desc(1, 0, 64'h20000, 0, 0, 0);
        run_frame(10, 6, 1, "F");
        // R8: exact fill of the whole table
        run_frame(24, 7, 1, "G");
        // R7/R9: table without end bit ends at the entry limit
        run_frame(40, 8, 0, "H");
        chk(rd_ptr == 8'h00, "R2 rollover back to 00", rd_ptr, 0);
        chk(ring_full, "R3 full again", ring_full, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule